// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps the VLAN membership table of a small Ethernet switch with up to seven ports. Each table entry holds a 12-bit VLAN ID, a 12-bit filtering ID, a 6-bit spanning-tree ID, a valid flag and a 2-bit membership code for each port. A second, smaller table holds one valid flag per spanning-tree ID. Frame forwarding, address learning and per-VLAN port states are handled elsewhere.

A host reaches the block through a 16-bit register port with a one-cycle registered read. It first writes the operand registers. It then writes an opcode to the operation register with the busy bit set. The engine walks the table one entry at a time, posts any result into the operand registers, and clears busy. The host polls busy and reads the results once busy is clear. There are four operations: flush the table, load or purge one VLAN entry, find the next valid entry above a given VLAN ID, and load or purge one spanning-tree entry.

Top module: `vlan_tbl_engine`

## Requirements
- R1: After reset, the operation register (address 0x5) and the VLAN ID register (address 0x6) read 0. The table has no valid VLAN entries, and every spanning-tree entry is invalid.
- R2: A write to address 0x5 with bit 15 set starts the operation coded in bits 14:12 (1 flush, 3 VLAN load/purge, 4 VLAN get-next, 5 spanning-tree load/purge). Bit 15 reads 1 from the next cycle on. It returns to 0 by itself within a bounded number of cycles. Bits 14:12 read back the last opcode written.
- R3: While busy is set, writes to any register are ignored, and that includes a second operation start.
- R4: Membership code bits [1:0] of port p (p<4) sit at bits [4p+1:4p] of address 0x7. For p>=4 they sit at bits [4(p-4)+1:4(p-4)] of address 0x8. The filtering ID (address 0x2, 12 bits) and the spanning-tree ID (address 0x3, 6 bits) are masked on write. Unused bits read 0, and address 0x9 always reads 0.
- R5: Get-next uses the VLAN ID in bits 11:0 of address 0x6 as the key. It returns the valid entry with the lowest VLAN ID strictly greater than the key, and a key of 0xFFF returns the lowest valid entry. On a hit, address 0x6 reads {bit12=1, VID}, and the filtering ID, spanning-tree ID and membership registers take the entry's values.
- R6: When no entry qualifies, get-next sets address 0x6 to 0x0FFF (valid bit 12 clear).
- R7: VLAN load/purge with bit 12 of address 0x6 clear removes the entry with that VLAN ID. Purging an absent VLAN ID changes nothing.
- R8: VLAN load/purge with bit 12 set writes the operand registers into the entry with that VLAN ID if one exists. Otherwise it writes them into a free slot.
- R9: Loading a new VLAN ID into a full table (16 entries) leaves the table unchanged and sets sticky bit 8 of address 0x5. Writing address 0x5 with bit 8 set while idle clears that bit.
- R10: Flush (opcode 1) invalidates every VLAN entry.
- R11: Spanning-tree load/purge (opcode 5) sets the valid flag of the entry indexed by bits 5:0 of address 0x6 to the value of bit 12. Get-next skips VLAN entries whose spanning-tree entry is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for writes and reads |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data for the address of the previous cycle |

## Verification
On every cycle the assertions check that an accepted start raises busy, that busy ends within a bounded number of cycles, and that the operand registers hold still during a table walk. They also check that the full-violation bit stays set until it is cleared, and that the spare data address reads zero. The bench scenarios show the rest: the ascending order of a get-next walk, wrap-around from key 0xFFF, overwrite against a fresh slot, purge of an absent ID, refusal when the table is full, spanning-tree gating, flush, and the writes that are dropped while busy.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 16;
  localparam int VID_W  = 12;
  localparam int FID_W  = 12;
  localparam int SID_W  = 6;
  localparam int CODE_W = 2;

  localparam logic [REG_AW-1:0] A_FID = 4'h2;
  localparam logic [REG_AW-1:0] A_SID = 4'h3;
  localparam logic [REG_AW-1:0] A_OP  = 4'h5;
  localparam logic [REG_AW-1:0] A_VID = 4'h6;
  localparam logic [REG_AW-1:0] A_DLO = 4'h7;
  localparam logic [REG_AW-1:0] A_DHI = 4'h8;
  localparam logic [REG_AW-1:0] A_DX  = 4'h9;

  localparam logic [2:0] OPC_FLUSH = 3'd1;
  localparam logic [2:0] OPC_LOAD  = 3'd3;
  localparam logic [2:0] OPC_NEXT  = 3'd4;
  localparam logic [2:0] OPC_STU   = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} eng_state_t;
endpackage

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 44,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  input  logic             flush,
  output logic [DEPTH-1:0] valid_vec
);
  // payload array: no reset, synchronous read -> block RAM friendly
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_vec <= '0;
    end else begin
      if (wr_en)  valid_vec[wr_idx]  <= 1'b1;
      if (clr_en) valid_vec[clr_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/vlan_tbl_stu.sv
module vlan_tbl_stu #(
  parameter int IDW = 6,
  localparam int N = 1 << IDW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [IDW-1:0] wr_idx,
  input  logic           wr_val,
  output logic [N-1:0]   valid_vec
);
  always_ff @(posedge clk) begin
    if (rst)        valid_vec <= '0;
    else if (wr_en) valid_vec[wr_idx] <= wr_val;
  end
endmodule

// File: rtl/vlan_tbl_engine.sv
module vlan_tbl_engine
  import vlan_tbl_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = IDX_W + 1;
  localparam int MEM_W = PORTS * CODE_W;
  localparam int P_FID = VID_W;
  localparam int P_SID = VID_W + FID_W;
  localparam int P_MEM = VID_W + FID_W + SID_W;
  localparam int PAY_W = P_MEM + MEM_W;
  localparam int VLD_B = VID_W;

  eng_state_t        state_q;
  logic [VID_W-1:0]  vid_q;
  logic              vld_q;
  logic [FID_W-1:0]  fid_q;
  logic [SID_W-1:0]  sid_q;
  logic [MEM_W-1:0]  mem_q;
  logic [2:0]        opcode_q;
  logic              full_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              match_found_q, free_found_q, best_found_q;
  logic [IDX_W-1:0]  match_idx_q, free_idx_q;
  logic [PAY_W-1:0]  best_q;

  logic              busy, scanning;
  logic [PAY_W-1:0]  rd_data;
  logic [ENTRIES-1:0] valid_vec;
  logic [(1<<SID_W)-1:0] stu_vec;

  assign busy     = (state_q != ST_IDLE);
  assign scanning = (state_q == ST_SCAN);

  // scan pipeline: cycle c reads slot c, evaluates slot c-1
  logic [IDX_W-1:0] ev_idx;
  logic             ev_on, ev_valid, ev_stu_ok, next_hit;
  logic [VID_W-1:0] ev_vid;
  logic [SID_W-1:0] ev_sid;

  assign ev_idx    = IDX_W'(cnt_q - 1'b1);
  assign ev_on     = scanning && (cnt_q != '0);
  assign ev_valid  = valid_vec[ev_idx];
  assign ev_vid    = rd_data[VID_W-1:0];
  assign ev_sid    = rd_data[P_SID +: SID_W];
  assign ev_stu_ok = stu_vec[ev_sid];
  assign next_hit  = ev_on && ev_valid && ev_stu_ok
                   && ((vid_q == '1) || (ev_vid > vid_q))
                   && (!best_found_q || (ev_vid < best_q[VID_W-1:0]));

  // table side effects, all issued in the completion cycle
  logic             done_cyc;
  logic             st_wr, st_clr, st_flush, stu_wr;
  logic [IDX_W-1:0] st_wr_idx;

  assign done_cyc  = (state_q == ST_DONE);
  assign st_wr     = done_cyc && (opcode_q == OPC_LOAD) && vld_q
                   && (match_found_q || free_found_q);
  assign st_wr_idx = match_found_q ? match_idx_q : free_idx_q;
  assign st_clr    = done_cyc && (opcode_q == OPC_LOAD) && !vld_q && match_found_q;
  assign st_flush  = done_cyc && (opcode_q == OPC_FLUSH);
  assign stu_wr    = done_cyc && (opcode_q == OPC_STU);

  vlan_tbl_store #(.DEPTH(ENTRIES), .WIDTH(PAY_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(cnt_q[IDX_W-1:0]), .rd_data(rd_data),
    .wr_en(st_wr), .wr_idx(st_wr_idx), .wr_data({mem_q, sid_q, fid_q, vid_q}),
    .clr_en(st_clr), .clr_idx(match_idx_q),
    .flush(st_flush), .valid_vec(valid_vec)
  );

  vlan_tbl_stu #(.IDW(SID_W)) u_stu (
    .clk(clk), .rst(rst),
    .wr_en(stu_wr), .wr_idx(vid_q[SID_W-1:0]), .wr_val(vld_q),
    .valid_vec(stu_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      vid_q         <= '0;
      vld_q         <= 1'b0;
      fid_q         <= '0;
      sid_q         <= '0;
      mem_q         <= '0;
      opcode_q      <= '0;
      full_q        <= 1'b0;
      cnt_q         <= '0;
      match_found_q <= 1'b0;
      free_found_q  <= 1'b0;
      best_found_q  <= 1'b0;
      match_idx_q   <= '0;
      free_idx_q    <= '0;
      best_q        <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (wr_en) begin
            case (addr)
              A_FID: fid_q <= wdata[FID_W-1:0];
              A_SID: sid_q <= wdata[SID_W-1:0];
              A_VID: begin
                vid_q <= wdata[VID_W-1:0];
                vld_q <= wdata[VLD_B];
              end
              A_DLO: for (int p = 0; p < PORTS; p++)
                       if (p < 4) mem_q[p*CODE_W +: CODE_W] <= wdata[(p%4)*4 +: CODE_W];
              A_DHI: for (int p = 0; p < PORTS; p++)
                       if (p >= 4) mem_q[p*CODE_W +: CODE_W] <= wdata[(p%4)*4 +: CODE_W];
              A_OP: begin
                opcode_q <= wdata[14:12];
                if (wdata[8]) full_q <= 1'b0;
                if (wdata[15]) begin
                  cnt_q         <= '0;
                  match_found_q <= 1'b0;
                  free_found_q  <= 1'b0;
                  best_found_q  <= 1'b0;
                  state_q <= (wdata[14:12] == OPC_LOAD || wdata[14:12] == OPC_NEXT)
                             ? ST_SCAN : ST_DONE;
                end
              end
              default: ;
            endcase
          end
        end
        ST_SCAN: begin
          cnt_q <= cnt_q + 1'b1;
          if (ev_on && opcode_q == OPC_LOAD) begin
            if (ev_valid && ev_vid == vid_q && !match_found_q) begin
              match_found_q <= 1'b1;
              match_idx_q   <= ev_idx;
            end
            if (!ev_valid && !free_found_q) begin
              free_found_q <= 1'b1;
              free_idx_q   <= ev_idx;
            end
          end
          if (opcode_q == OPC_NEXT && next_hit) begin
            best_found_q <= 1'b1;
            best_q       <= rd_data;
          end
          if (cnt_q == CNT_W'(ENTRIES)) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (opcode_q == OPC_LOAD && vld_q && !match_found_q && !free_found_q)
            full_q <= 1'b1;
          if (opcode_q == OPC_NEXT) begin
            if (best_found_q) begin
              vid_q <= best_q[VID_W-1:0];
              vld_q <= 1'b1;
              fid_q <= best_q[P_FID +: FID_W];
              sid_q <= best_q[P_SID +: SID_W];
              mem_q <= best_q[P_MEM +: MEM_W];
            end else begin
              vid_q <= '1;
              vld_q <= 1'b0;
            end
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [REG_DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_FID: rd_mux[FID_W-1:0] = fid_q;
      A_SID: rd_mux[SID_W-1:0] = sid_q;
      A_OP:  rd_mux = {busy, opcode_q, 3'b000, full_q, 8'h00};
      A_VID: rd_mux[VLD_B:0] = {vld_q, vid_q};
      A_DLO: for (int p = 0; p < PORTS; p++)
               if (p < 4) rd_mux[(p%4)*4 +: CODE_W] = mem_q[p*CODE_W +: CODE_W];
      A_DHI: for (int p = 0; p < PORTS; p++)
               if (p >= 4) rd_mux[(p%4)*4 +: CODE_W] = mem_q[p*CODE_W +: CODE_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/vlan_tbl_engine_chk.sv
module vlan_tbl_engine_chk
  import vlan_tbl_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [REG_DW-1:0] wdata,
  input logic [REG_DW-1:0] rdata,
  input logic              busy,
  input logic              scanning,
  input logic              full,
  input logic [VID_W-1:0]  vid_reg,
  input logic [FID_W-1:0]  fid_reg
);
  localparam int LIMIT = 2 * ENTRIES + 4;
  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  logic start_req, clear_req;
  assign start_req = wr_en && (addr == A_OP) && wdata[15] && !busy;
  assign clear_req = wr_en && (addr == A_OP) && wdata[8] && !busy;

  a_r2_busy_starts: assert property (@(posedge clk) disable iff (rst)
    start_req |=> busy);

  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < 16'(LIMIT)));

  a_r3_operands_frozen: assert property (@(posedge clk) disable iff (rst)
    scanning |=> ($stable(vid_reg) && $stable(fid_reg)));

  a_r9_full_sticky: assert property (@(posedge clk) disable iff (rst)
    (full && !clear_req) |=> full);

  a_r4_spare_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == A_DX) |=> (rdata == '0));
endmodule

bind vlan_tbl_engine vlan_tbl_engine_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .busy(busy), .scanning(scanning), .full(full_q),
  .vid_reg(vid_q), .fid_reg(fid_q)
);

// File: tb/vlan_tbl_engine_tb.sv
module vlan_tbl_engine_tb;
  import vlan_tbl_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 16;
  localparam int PORTS = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [REG_AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_tbl_engine #(.ENTRIES(ENTRIES), .PORTS(PORTS)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] m_vid [ENTRIES];
  logic [11:0] m_fid [ENTRIES];
  logic [5:0]  m_sid [ENTRIES];
  logic [13:0] m_mem [ENTRIES];
  bit          m_val [ENTRIES];
  bit          m_stu [64];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] v;
    int n = 0;
    do begin rd(A_OP, v); n++; end while (v[15] && n < 200);
    check(tag, 16'(v[15]), 16'h0);
  endtask

  task automatic run_op(input logic [2:0] opc, input string tag);
    wr(A_OP, {1'b1, opc, 12'h000});
    wait_idle(tag);
  endtask

  function automatic logic [15:0] pack_lo(input logic [13:0] m);
    logic [15:0] r = '0;
    for (int p = 0; p < 4; p++) r[4*p +: 2] = m[2*p +: 2];
    return r;
  endfunction

  function automatic logic [15:0] pack_hi(input logic [13:0] m);
    logic [15:0] r = '0;
    for (int p = 4; p < 7; p++) r[4*(p-4) +: 2] = m[2*p +: 2];
    return r;
  endfunction

  function automatic int m_next(input logic [11:0] key);
    int best = -1;
    for (int i = 0; i < ENTRIES; i++)
      if (m_val[i] && m_stu[m_sid[i]] && (key == 12'hFFF || m_vid[i] > key)
          && (best < 0 || m_vid[i] < m_vid[best])) best = i;
    return best;
  endfunction

  // model of load/purge; returns 1 when the load is refused for lack of room
  function automatic bit m_load(input logic [11:0] v, input logic [11:0] f,
                                input logic [5:0] s, input logic [13:0] m, input bit vld);
    int hit = -1, fr = -1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (m_val[i] && m_vid[i] == v && hit < 0) hit = i;
      if (!m_val[i] && fr < 0) fr = i;
    end
    if (!vld) begin
      if (hit >= 0) m_val[hit] = 1'b0;
      return 1'b0;
    end
    if (hit < 0) hit = fr;
    if (hit < 0) return 1'b1;
    m_val[hit] = 1'b1; m_vid[hit] = v; m_fid[hit] = f; m_sid[hit] = s; m_mem[hit] = m;
    return 1'b0;
  endfunction

  task automatic load_entry(input logic [11:0] v, input logic [11:0] f, input logic [5:0] s,
                            input logic [13:0] m, input bit vld, output bit refused);
    wr(A_FID, 16'hF000 | 16'(f));
    wr(A_SID, 16'hFFC0 | 16'(s));
    wr(A_DLO, pack_lo(m) | 16'hCCCC);
    wr(A_DHI, pack_hi(m) | 16'hFCCC);
    wr(A_VID, {3'b000, vld, v});
    run_op(OPC_LOAD, "R2 load completes");
    refused = m_load(v, f, s, m, vld);
  endtask

  task automatic getnext(input logic [11:0] key, input string tag, output bit found,
                         output logic [11:0] fv);
    logic [15:0] v;
    int idx;
    wr(A_VID, {4'h0, key});
    run_op(OPC_NEXT, "R2 get-next completes");
    idx = m_next(key);
    rd(A_VID, v);
    found = (idx >= 0);
    fv = v[11:0];
    if (idx < 0) begin
      check({tag, " R6 miss"}, v, 16'h0FFF);
    end else begin
      check({tag, " R5 vid"}, v, {4'h1, m_vid[idx]});
      rd(A_FID, v); check({tag, " R4 fid"}, v, 16'(m_fid[idx]));
      rd(A_SID, v); check({tag, " R4 sid"}, v, 16'(m_sid[idx]));
      rd(A_DLO, v); check({tag, " R4 ports0-3"}, v, pack_lo(m_mem[idx]));
      rd(A_DHI, v); check({tag, " R4 ports4-6"}, v, pack_hi(m_mem[idx]));
    end
  endtask

  // walk the whole table in ascending order, checking each step
  task automatic walk(input string tag);
    logic [11:0] key = 12'hFFF;
    logic [11:0] fv;
    bit found;
    int steps = 0, expn = 0;
    for (int i = 0; i < ENTRIES; i++) if (m_val[i] && m_stu[m_sid[i]]) expn++;
    for (int k = 0; k < ENTRIES + 2; k++) begin
      getnext(key, tag, found, fv);
      if (!found) break;
      steps++;
      key = fv;
    end
    check({tag, " R5 walk length"}, 16'(steps), 16'(expn));
  endtask

  function automatic logic [13:0] codes_for(input int k);
    logic [13:0] r;
    for (int p = 0; p < 7; p++) r[2*p +: 2] = 2'((k + p) % 4);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [11:0] fv;
    bit found, refused;
    for (int i = 0; i < ENTRIES; i++) m_val[i] = 1'b0;
    for (int i = 0; i < 64; i++) m_stu[i] = 1'b0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_OP, v);  check("R1 op reg after reset", v, 16'h0000);
    rd(A_VID, v); check("R1 vid reg after reset", v, 16'h0000);
    getnext(12'hFFF, "R1 empty table", found, fv);

    // R4 operand masking and spare address
    wr(A_FID, 16'hFABC); rd(A_FID, v); check("R4 fid mask", v, 16'h0ABC);
    wr(A_SID, 16'hFFFF); rd(A_SID, v); check("R4 sid mask", v, 16'h003F);
    wr(A_DLO, 16'hFFFF); rd(A_DLO, v); check("R4 ports0-3 mask", v, 16'h3333);
    wr(A_DHI, 16'hFFFF); rd(A_DHI, v); check("R4 ports4-6 mask", v, 16'h0333);
    rd(A_DX, v); check("R4 spare address", v, 16'h0000);

    // R11 entry pointing at an invalid spanning-tree entry stays hidden
    load_entry(12'd10, 12'h0AA, 6'd0, codes_for(9), 1'b1, refused);
    getnext(12'hFFF, "R11 stu invalid", found, fv);
    check("R11 hidden entry", 16'(found), 16'h0);
    wr(A_VID, 16'h1000); run_op(OPC_STU, "R11 stu load 0"); m_stu[0] = 1'b1;
    wr(A_VID, 16'h1005); run_op(OPC_STU, "R11 stu load 5"); m_stu[5] = 1'b1;
    getnext(12'hFFF, "R11 stu valid", found, fv);
    check("R11 visible entry", {4'h0, fv}, 16'd10);

    // load a spread of entries and walk them
    for (int k = 0; k < 12; k++)
      load_entry(12'(k*37 + 3), 12'((k*37 + 3) ^ 12'h5A5), 6'((k % 2) * 5),
                 codes_for(k), 1'b1, refused);
    walk("R5 initial");
    for (int k = 0; k < 12; k++) getnext(12'(k*37 + 2), "R5 key below", found, fv);
    getnext(12'd0, "R5 key zero", found, fv);
    getnext(12'd410, "R6 above all", found, fv);

    // R8 overwrite keeps slot count
    load_entry(12'd3, 12'h777, 6'd5, 14'h2A5B, 1'b1, refused);
    getnext(12'd2, "R8 overwrite", found, fv);
    walk("R8 after overwrite");

    // R7 purge present and absent
    load_entry(12'd40, 12'h0, 6'd0, 14'h0, 1'b0, refused);
    getnext(12'd39, "R7 purged", found, fv);
    check("R7 purged skip", {4'h0, fv}, 16'd77);
    load_entry(12'h800, 12'h0, 6'd0, 14'h0, 1'b0, refused);
    walk("R7 absent purge");

    // R9 fill to 16, then one more
    for (int k = 0; k < 4; k++)
      load_entry(12'(12'h900 + k), 12'(k), 6'd0, codes_for(k + 3), 1'b1, refused);
    rd(A_OP, v); check("R9 no violation yet", v, 16'h3000);
    load_entry(12'h904, 12'h123, 6'd0, 14'h0, 1'b1, refused);
    check("R9 model refused", 16'(refused), 16'h1);
    rd(A_OP, v); check("R9 violation bit", v, 16'h3100);
    getnext(12'h903, "R9 table unchanged", found, fv);
    rd(A_OP, v); check("R9 sticky across op", v, 16'h4100);
    load_entry(12'h900, 12'h456, 6'd5, 14'h1111, 1'b1, refused);
    getnext(12'h8FF, "R9 overwrite in full table", found, fv);
    wr(A_OP, 16'h0100); rd(A_OP, v); check("R9 clear", v, 16'h0000);

    // R11 purge spanning-tree entry 5
    wr(A_VID, 16'h0005); run_op(OPC_STU, "R11 stu purge"); m_stu[5] = 1'b0;
    walk("R11 after stu purge");

    // R3 writes ignored while busy; R2 busy readback
    wr(A_FID, 16'h0111);
    wr(A_VID, 16'h0FFE);
    wr(A_OP, 16'hC000);
    wr(A_FID, 16'h0777);
    wr(A_OP, 16'h9000);
    rd(A_OP, v); check("R2 busy and opcode", v, 16'hC000);
    wait_idle("R2 busy clears");
    rd(A_FID, v); check("R3 fid write dropped", v, 16'h0111);
    rd(A_VID, v); check("R6 key 0xFFE miss", v, 16'h0FFF);
    rd(A_OP, v); check("R3 op write dropped", v, 16'h4000);
    walk("R3 no flush happened");

    // R10 flush
    run_op(OPC_FLUSH, "R10 flush completes");
    for (int i = 0; i < ENTRIES; i++) m_val[i] = 1'b0;
    getnext(12'hFFF, "R10 after flush", found, fv);
    check("R10 table empty", 16'(found), 16'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule